// File: doc/BRIEF.md
# Configurable Register Field Cell

This block holds a single field of a control/status register. Software reaches it through an already decoded register-select write strobe and read strobe. These come with the write data word and its per-byte enables. Hardware can load the field from a data input, optionally qualified by an enable of either polarity. The stored value goes back to hardware together with its AND, OR and XOR reductions.

Parameters fix everything else at build time:

- the field's width and where it sits in the bus word;
- the kind of reset;
- what a software write does to the bits;
- whether a read clears or sets the field;
- whether an external signal enables or locks software writes;
- which of hardware and software is applied last in a cycle where both write;
- whether the field falls back to zero one cycle after any update.

An address decoder and a read multiplexer surround the cell in a register bank. Each field of the bank is one instance.

Top module: `regfield_cell`

## Requirements
- R1: With `rst` active (high when RST_HIGH=1, low when 0) the field holds RST_VAL. When RST_ASYNC=1 the field is forced at once without waiting for a clock edge. When RST_ASYNC=0 it is loaded at the next rising clock edge only.
- R2: When HW_WR=1, a hardware write loads `hw_d` at the next edge. With HW_WE=1 the write needs `hw_wen`=1 if HW_WE_LOW=0, or `hw_wen`=0 if HW_WE_LOW=1. With HW_WE=0 hardware writes every cycle.
- R3: A software write needs `sw_wr`=1. SW_GATE selects the gating: 0 means no gating, 1 means `sw_gate` must be 1, and 2 means `sw_gate` acts as a lock and must be 0.
- R4: With WMODE=0, field bit i maps to bus bit LSB+i. That bit is copied from `sw_wdata` only when `sw_be[(LSB+i)/8]` is 1, so a field that crosses a byte boundary is updated one byte at a time.
- R5: Within enabled bytes, a one in the data sets the bit when WMODE=1, clears it when WMODE=2 and inverts it when WMODE=3. A zero in the data leaves the bit as it is.
- R6: Within enabled bytes, WMODE=4 clears each bit whose data bit is zero, so the field is ANDed with the data. WMODE=5 inverts each bit whose data bit is zero, so the field is XNORed with the data. Ones leave bits alone.
- R7: On any permitted software write, WMODE=6 makes the whole field zero and WMODE=7 makes it all ones, whatever the byte enables.
- R8: `sw_rd`=1 makes the field zero when RMODE=1 and all ones when RMODE=2. It has no effect when RMODE=0. A read effect is applied after any write in the same cycle.
- R9: In a cycle with both a hardware and a software write, SW_LAST=1 applies the software update to the hardware-loaded value. SW_LAST=0 lets the hardware value win.
- R10: With PULSE=1 the field is zero in every cycle that follows a cycle without an update, so a written value is seen for exactly one cycle.
- R11: `q_and`, `q_or` and `q_xor` are the AND, OR and XOR of all bits of `q`.
- R12: In a cycle without a hardware write, a permitted software write or a read effect, a field with PULSE=0 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, polarity set by RST_HIGH |
| sw_wr | input | 1 | Decoded software write strobe for this register |
| sw_rd | input | 1 | Decoded software read strobe for this register |
| sw_wdata | input | BUS_W | Software write data word |
| sw_be | input | BUS_W/8 | Byte enables of the write data |
| sw_gate | input | 1 | External software write enable or lock |
| hw_wen | input | 1 | Hardware write enable |
| hw_d | input | FW | Hardware write data |
| q | output | FW | Stored field value |
| q_and | output | 1 | AND reduction of the field |
| q_or | output | 1 | OR reduction of the field |
| q_xor | output | 1 | XOR reduction of the field |

## Verification
Nine cells run side by side from one stimulus stream. Between them they cover every write mode, both read effects, both precedences, all gating and enable polarities and every reset style.

- Full-word writes, single-byte writes and alternating-byte writes separate correct per-byte slicing from whole-field behaviour. Fields that cross a byte boundary expose an off-by-LSB bit mapping.
- All-zero and mixed data patterns tell the one-acting modes apart from the zero-acting modes.
- Cycles with both a hardware and a software write, and writes combined with reads, show the order in which updates are applied.
- A reset raised between clock edges separates the asynchronous cells, which change at once, from the synchronous cells, which wait for the edge.
- Pseudo-random traffic then mixes all of these inputs.

// File: rtl/regfield_cell.sv
module regfield_cell #(
  parameter int       BUS_W     = 32,
  parameter int       FW        = 12,
  parameter int       LSB       = 4,
  parameter logic [FW-1:0] RST_VAL = '0,
  parameter bit       RST_ASYNC = 1'b1,
  parameter bit       RST_HIGH  = 1'b0,
  parameter bit       HW_WR     = 1'b1,
  parameter bit       HW_WE     = 1'b1,
  parameter bit       HW_WE_LOW = 1'b0,
  parameter bit       SW_LAST   = 1'b1,
  parameter int       SW_GATE   = 0,
  parameter int       WMODE     = 0,
  parameter int       RMODE     = 0,
  parameter bit       PULSE     = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_wr,
  input  logic               sw_rd,
  input  logic [BUS_W-1:0]   sw_wdata,
  input  logic [BUS_W/8-1:0] sw_be,
  input  logic               sw_gate,
  input  logic               hw_wen,
  input  logic [FW-1:0]      hw_d,
  output logic [FW-1:0]      q,
  output logic               q_and,
  output logic               q_or,
  output logic               q_xor
);
  localparam logic [FW-1:0] ONES = '1;

  logic [FW-1:0] q_r, base, wd, bmask, nxt;
  logic          rst_on, hw_go, sw_go, rd_go, gate_ok;
  logic          unused_in;

  assign unused_in = ^{sw_wdata, sw_be, sw_gate, hw_wen, hw_d};

  assign rst_on  = RST_HIGH ? rst : !rst;
  assign wd      = sw_wdata[LSB +: FW];
  assign base    = PULSE ? '0 : q_r;
  assign gate_ok = (SW_GATE == 1) ? sw_gate : (SW_GATE == 2) ? !sw_gate : 1'b1;
  assign hw_go   = HW_WR && (!HW_WE || (hw_wen ^ HW_WE_LOW));
  assign sw_go   = sw_wr && gate_ok;
  assign rd_go   = sw_rd && (RMODE != 0);

  for (genvar i = 0; i < FW; i++) begin : g_bmask
    assign bmask[i] = sw_be[(LSB + i) / 8];
  end

  function automatic logic [FW-1:0] sw_apply(input logic [FW-1:0] cur, d, m);
    case (WMODE)
      1:       return cur | (d & m);
      2:       return cur & ~(d & m);
      3:       return cur ^ (d & m);
      4:       return cur & (d | ~m);
      5:       return cur ^ (~d & m);
      6:       return '0;
      7:       return ONES;
      default: return (cur & ~m) | (d & m);
    endcase
  endfunction

  always_comb begin
    nxt = base;
    if (SW_LAST) begin
      if (hw_go) nxt = hw_d;
      if (sw_go) nxt = sw_apply(nxt, wd, bmask);
    end else begin
      if (sw_go) nxt = sw_apply(nxt, wd, bmask);
      if (hw_go) nxt = hw_d;
    end
    if (rd_go) nxt = (RMODE == 2) ? ONES : '0;
  end

  if (RST_ASYNC && RST_HIGH) begin : g_arst_hi
    always_ff @(posedge clk or posedge rst)
      if (rst) q_r <= RST_VAL;
      else     q_r <= nxt;
  end else if (RST_ASYNC) begin : g_arst_lo
    always_ff @(posedge clk or negedge rst)
      if (!rst) q_r <= RST_VAL;
      else      q_r <= nxt;
  end else begin : g_srst
    always_ff @(posedge clk)
      if (rst_on) q_r <= RST_VAL;
      else        q_r <= nxt;
  end

  assign q     = q_r;
  assign q_and = &q_r;
  assign q_or  = |q_r;
  assign q_xor = ^q_r;

  p_rst_val_r1: assert property (@(posedge clk)
    ($past(rst_on) && !rst_on) |-> q_r == RST_VAL);

  p_hw_load_r2: assert property (@(posedge clk) disable iff (rst_on)
    (hw_go && !(sw_go && SW_LAST) && !rd_go) |=> q_r == $past(hw_d));

  p_rd_effect_r8: assert property (@(posedge clk) disable iff (rst_on)
    rd_go |=> q_r == ((RMODE == 2) ? ONES : '0));

  p_pulse_zero_r10: assert property (@(posedge clk) disable iff (rst_on)
    (PULSE && !hw_go && !sw_go && !rd_go) |=> q_r == '0);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst_on)
    (!PULSE && !hw_go && !sw_go && !rd_go) |=> $stable(q_r));
endmodule

// File: tb/regfield_cell_tb.sv
module regfield_cell_tb;
  localparam int N = 9;
  localparam int FWv [N] = '{12, 8, 8, 8, 8, 8, 4, 16, 1};
  localparam int LSBv[N] = '{4, 12, 12, 12, 12, 12, 0, 8, 31};
  localparam int WMv [N] = '{0, 1, 2, 3, 4, 5, 6, 7, 0};
  localparam int RMv [N] = '{0, 0, 0, 0, 0, 0, 2, 1, 0};
  localparam int HWv [N] = '{1, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam int HWEv[N] = '{1, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int HWLv[N] = '{0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int SWLv[N] = '{1, 1, 1, 1, 1, 1, 0, 1, 1};
  localparam int GTv [N] = '{0, 0, 0, 0, 0, 0, 2, 1, 0};
  localparam int PLv [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam int ASYv[N] = '{1, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam logic [15:0] RSTV[N] = '{16'h05A5, 16'h003C, 16'h003C, 16'h003C,
                                      16'h003C, 16'h003C, 16'h0009, 16'hBEEF, 16'h0000};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, rst_p;
  logic        sw_wr, sw_rd, sw_gate, hw_wen;
  logic [31:0] wd;
  logic [3:0]  be;
  logic [15:0] hd;
  logic [15:0] qv [N];
  logic        ra [N], ro [N], rx [N];
  logic [15:0] mq [N];

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  string tq[$];
  logic [N-1:0][15:0] eq[$];

  assign rst_p = ~rst_n;

  logic [11:0] qa;
  regfield_cell #(.BUS_W(32), .FW(12), .LSB(4), .RST_VAL(12'h5A5), .RST_ASYNC(1'b1),
    .RST_HIGH(1'b0), .HW_WR(1'b1), .HW_WE(1'b1), .HW_WE_LOW(1'b0), .SW_LAST(1'b1),
    .SW_GATE(0), .WMODE(0), .RMODE(0), .PULSE(1'b0)) u_dut (
    .clk(clk), .rst(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(wd), .sw_be(be),
    .sw_gate(sw_gate), .hw_wen(hw_wen), .hw_d(hd[11:0]), .q(qa),
    .q_and(ra[0]), .q_or(ro[0]), .q_xor(rx[0]));
  assign qv[0] = {4'h0, qa};

  for (genvar m = 1; m <= 5; m++) begin : g_mode
    logic [7:0] qm;
    regfield_cell #(.BUS_W(32), .FW(8), .LSB(12), .RST_VAL(RSTV[m][7:0]), .RST_ASYNC(1'b0),
      .RST_HIGH(1'b1), .HW_WR(1'b0), .HW_WE(1'b0), .HW_WE_LOW(1'b0), .SW_LAST(1'b1),
      .SW_GATE(0), .WMODE(m), .RMODE(0), .PULSE(1'b0)) u_m (
      .clk(clk), .rst(rst_p), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(wd), .sw_be(be),
      .sw_gate(sw_gate), .hw_wen(hw_wen), .hw_d(hd[7:0]), .q(qm),
      .q_and(ra[m]), .q_or(ro[m]), .q_xor(rx[m]));
    assign qv[m] = {8'h00, qm};
  end

  logic [3:0] qc;
  regfield_cell #(.BUS_W(32), .FW(4), .LSB(0), .RST_VAL(4'h9), .RST_ASYNC(1'b0),
    .RST_HIGH(1'b0), .HW_WR(1'b1), .HW_WE(1'b1), .HW_WE_LOW(1'b1), .SW_LAST(1'b0),
    .SW_GATE(2), .WMODE(6), .RMODE(2), .PULSE(1'b0)) u_c (
    .clk(clk), .rst(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(wd), .sw_be(be),
    .sw_gate(sw_gate), .hw_wen(hw_wen), .hw_d(hd[3:0]), .q(qc),
    .q_and(ra[6]), .q_or(ro[6]), .q_xor(rx[6]));
  assign qv[6] = {12'h000, qc};

  regfield_cell #(.BUS_W(32), .FW(16), .LSB(8), .RST_VAL(16'hBEEF), .RST_ASYNC(1'b1),
    .RST_HIGH(1'b0), .HW_WR(1'b1), .HW_WE(1'b0), .HW_WE_LOW(1'b0), .SW_LAST(1'b1),
    .SW_GATE(1), .WMODE(7), .RMODE(1), .PULSE(1'b0)) u_d (
    .clk(clk), .rst(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(wd), .sw_be(be),
    .sw_gate(sw_gate), .hw_wen(hw_wen), .hw_d(hd), .q(qv[7]),
    .q_and(ra[7]), .q_or(ro[7]), .q_xor(rx[7]));

  logic [0:0] qe;
  regfield_cell #(.BUS_W(32), .FW(1), .LSB(31), .RST_VAL(1'b0), .RST_ASYNC(1'b1),
    .RST_HIGH(1'b1), .HW_WR(1'b0), .HW_WE(1'b0), .HW_WE_LOW(1'b0), .SW_LAST(1'b1),
    .SW_GATE(0), .WMODE(0), .RMODE(0), .PULSE(1'b1)) u_e (
    .clk(clk), .rst(rst_p), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(wd), .sw_be(be),
    .sw_gate(sw_gate), .hw_wen(hw_wen), .hw_d(hd[0:0]), .q(qe),
    .q_and(ra[8]), .q_or(ro[8]), .q_xor(rx[8]));
  assign qv[8] = {15'h0000, qe};

  function automatic logic [15:0] fmask(int k);
    return (FWv[k] == 16) ? 16'hFFFF : ((16'h1 << FWv[k]) - 16'h1);
  endfunction

  function automatic logic [15:0] sw_model(int k, logic [15:0] cur, logic [31:0] d, logic [3:0] b);
    logic [15:0] v = cur;
    if (WMv[k] == 6) return 16'h0000;
    if (WMv[k] == 7) return fmask(k);
    for (int i = 0; i < FWv[k]; i++) begin
      int  bit_pos = LSBv[k] + i;
      bit  en = b[bit_pos / 8];
      bit  db = d[bit_pos];
      if (en) begin
        case (WMv[k])
          0: v[i] = db;
          1: if (db) v[i] = 1'b1;
          2: if (db) v[i] = 1'b0;
          3: if (db) v[i] = ~v[i];
          4: if (!db) v[i] = 1'b0;
          5: if (!db) v[i] = ~v[i];
          default: ;
        endcase
      end
    end
    return v;
  endfunction

  function automatic logic [15:0] model(int k, logic [15:0] cur, bit w, bit r, bit g, bit hen,
                                        logic [31:0] d, logic [3:0] b, logic [15:0] h);
    logic [15:0] v = PLv[k] ? 16'h0000 : cur;
    bit hwgo = (HWv[k] != 0) && ((HWEv[k] == 0) || (hen != HWLv[k]));
    bit swgo = w && ((GTv[k] == 0) || (GTv[k] == 1 && g) || (GTv[k] == 2 && !g));
    if (SWLv[k] != 0) begin
      if (hwgo) v = h;
      if (swgo) v = sw_model(k, v, d, b);
    end else begin
      if (swgo) v = sw_model(k, v, d, b);
      if (hwgo) v = h;
    end
    if (r && RMv[k] == 1) v = 16'h0000;
    if (r && RMv[k] == 2) v = 16'hFFFF;
    return v & fmask(k);
  endfunction

  task automatic chk(string tag, string what, int k, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cell%0d: actual %h expected %h", tag, what, k, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, bit r, bit g, bit hen,
                      logic [31:0] d, logic [3:0] b, logic [15:0] h);
    logic [N-1:0][15:0] e;
    @(negedge clk);
    sw_wr = w; sw_rd = r; sw_gate = g; hw_wen = hen; wd = d; be = b; hd = h;
    for (int k = 0; k < N; k++) begin
      e[k] = model(k, mq[k], w, r, g, hen, d, b, h);
      mq[k] = e[k];
    end
    tq.push_back(tag);
    eq.push_back(e);
  endtask

  always @(posedge clk) begin : monitor
    logic [N-1:0][15:0] e;
    string t;
    #2;
    if (eq.size() > 0) begin
      e = eq.pop_front();
      t = tq.pop_front();
      for (int k = 0; k < N; k++) begin
        chk(t, "q", k, qv[k], e[k]);
        chk("R11", "reductions", k, {13'h0, ra[k], ro[k], rx[k]},
            {13'h0, &(e[k] | ~fmask(k)), |e[k], ^e[k]});
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    rst_n = 1'b0; sw_wr = 0; sw_rd = 0; sw_gate = 0; hw_wen = 0; wd = '0; be = '0; hd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < N; k++) begin
      chk("R1", "reset value", k, qv[k], RSTV[k]);
      mq[k] = RSTV[k];
    end

    step("R12", 0, 0, 0, 0, 32'h0, 4'h0, 16'h0);
    step("R4",  1, 0, 0, 0, 32'hA5C3_96F0, 4'hF, 16'h0);
    step("R4",  1, 0, 0, 0, 32'h1234_5678, 4'b0010, 16'h0);
    step("R10", 0, 0, 0, 0, 32'h0, 4'h0, 16'h0);
    step("R5",  1, 0, 0, 0, 32'hFFFF_FFFF, 4'b0101, 16'h0);
    step("R6",  1, 0, 0, 0, 32'h0000_0000, 4'hF, 16'h0);
    step("R5",  1, 0, 0, 0, 32'h0F0F_0F0F, 4'b0110, 16'h0);
    step("R6",  1, 0, 0, 0, 32'hF0F0_5A5A, 4'b0011, 16'h0);
    step("R2",  0, 0, 0, 1, 32'h0, 4'h0, 16'h0ABC);
    step("R2",  0, 0, 0, 0, 32'h0, 4'h0, 16'h1357);
    step("R9",  1, 0, 1, 1, 32'h8000_0550, 4'hF, 16'h0FED);
    step("R9",  1, 0, 0, 0, 32'h0000_0AA0, 4'b0001, 16'h0246);
    step("R3",  1, 0, 1, 1, 32'h0000_0F00, 4'hF, 16'h0000);
    step("R3",  1, 0, 0, 1, 32'h0000_0F00, 4'hF, 16'h0000);
    step("R7",  1, 0, 1, 1, 32'h0, 4'h0, 16'h4444);
    step("R7",  1, 0, 0, 1, 32'h0, 4'h0, 16'h4444);
    step("R8",  0, 1, 0, 1, 32'h0, 4'h0, 16'h7777);
    step("R8",  1, 1, 1, 1, 32'hFFFF_FFFF, 4'hF, 16'h3333);
    step("R12", 0, 0, 0, 1, 32'h0, 4'h0, 16'h0);

    x = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      step("R9", x[0], x[1] & x[2], x[3], x[4], {x[31:8], x[7:0] ^ x[15:8]}, x[11:8], x[27:12]);
    end

    step("R12", 0, 0, 0, 1, 32'h0, 4'h0, 16'h0);
    @(posedge clk);
    #6;
    rst_n = 1'b0;
    #2;
    for (int k = 0; k < N; k++)
      chk("R1", ASYv[k] != 0 ? "async reset now" : "sync reset waits",
          k, qv[k], ASYv[k] != 0 ? RSTV[k] : mq[k]);
    @(posedge clk);
    #2;
    for (int k = 0; k < N; k++) begin
      chk("R1", "reset after edge", k, qv[k], RSTV[k]);
      mq[k] = RSTV[k];
    end
    @(negedge clk);
    rst_n = 1'b1;
    step("R4", 1, 0, 1, 0, 32'hDEAD_BEEF, 4'hF, 16'h1111);
    step("R12", 0, 0, 0, 1, 32'h0, 4'h0, 16'h0);
    @(posedge clk);
    #5;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule